// File: doc/BRIEF.md
# I/Q Subcarrier Bit Demodulator

This block turns a stream of signed 8-bit I/Q sample pairs into card-to-reader data bits. A start pulse marks the end of the reader's own frame. The block then waits a fixed number of ticks and splits the following time into bit periods of a fixed length. In each period it counts the arriving sample pairs. It drops the leading pairs and sums a window of pairs for I and for Q separately. It estimates the subcarrier amplitude as the larger absolute sum plus half the smaller one, which avoids a square root, and compares the average against a fixed threshold.

In receive mode each decision is XORed with the current keystream bit. The result goes into a word, starting at bit 0. A keystream advance strobe fires once per period. In acknowledge mode the raw decision is used without descrambling: the block ends as soon as a period decides 1, or reports a timeout once the period limit is used up. Each bit period keeps its fixed length, so the start of the next period does not depend on when the sample window closed.

Top module: `iq_bit_demod`

## Requirements
- R1: After reset, busy, done, keyStep, ackSeen and ackTimeout are 0 and rxWord is all zeros.
- R2: On the clock edge that captures startRx while idle, busy rises. Samples offered during the next GAP_TICKS (495) cycles are ignored. The first bit period begins on the cycle after that.
- R3: Each bit period lasts BIT_TICKS (150) cycles. Within a period the valid sample pairs are numbered from 0. Pairs 0 to 4 are discarded, pairs 5 to 12 are summed, and every later pair is ignored. I is taken from sampleIq[15:8] and Q from sampleIq[7:0], both two's complement.
- R4: With S_I and S_Q the two sums, the amplitude is max(|S_I|,|S_Q|) + floor(min(|S_I|,|S_Q|)/2). A period decides 1 exactly when floor(amplitude/8) is greater than 8. The accumulators hold the full range of 8 summed samples without overflow.
- R5: In receive mode, bit k of rxWord (k from 0) is the decision of period k XOR the keyBit present in that period's last cycle. The number of periods is bitCount (1 to 32; 0 or more than 32 means 32). All higher bits of rxWord are 0, because rxWord clears at start.
- R6: keyStep is high in the last cycle of every bit period, in both modes, and low at all other times.
- R7: done pulses for one cycle on the edge after the final period, at the same time as busy falls. While idle, rxWord, ackSeen and ackTimeout hold until the next start.
- R8: In acknowledge mode (ackMode=1 at start) the raw decision is used without the keystream. The first period that decides 1 ends the operation with done and ackSeen=1.
- R9: If 60 acknowledge periods pass without a 1, the operation ends with done and ackTimeout=1. ackSeen and ackTimeout are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing tick |
| rstN | input | 1 | Asynchronous active-low reset |
| startRx | input | 1 | Reader frame ended; begin a receive or acknowledge wait |
| ackMode | input | 1 | Captured at start: 1 selects acknowledge wait |
| bitCount | input | 6 | Captured at start: number of bits to receive |
| sampleValid | input | 1 | Qualifies sampleIq this cycle |
| sampleIq | input | 16 | I in upper byte, Q in lower byte, signed |
| keyBit | input | 1 | Current keystream bit |
| keyStep | output | 1 | Advance the keystream (last cycle of each period) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rxWord | output | 32 | Descrambled received bits, LSB first |
| ackSeen | output | 1 | Acknowledge detected |
| ackTimeout | output | 1 | Acknowledge wait expired |

## Verification
A tick counter that is off by even one cycle moves the sample window against the pairs the bench places. The wrong pairs, including deliberately strong pairs in the discarded slots, then land in the sums and flip decisions in the very next rxWord. A wrong sample count or threshold compare shows up as wrong bits at the exact amplitude boundaries, one word after the fault. A keystream misalignment shows as a wrong keyStep count, or as bits inverted against the bench's own stepped sequence. Errors in the period counter show as done arriving one period early or late, in both receive and acknowledge modes.

// File: rtl/iq_demod_pkg.sv
package iq_demod_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_BITS = 2'd2
  } demod_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAcc;
    logic accEn;
    logic clrWord;
    logic storeBit;
  } dp_ctrl_t;

endpackage

// File: rtl/iq_demod_ctrl.sv
module iq_demod_ctrl
  import iq_demod_pkg::*;
#(
  parameter int GAP_TICKS   = 495,
  parameter int BIT_TICKS   = 150,
  parameter int SKIP_PAIRS  = 5,
  parameter int SUM_PAIRS   = 8,
  parameter int ACK_PERIODS = 60,
  parameter int WORD_W      = 32,
  localparam int MAX_TICK   = (GAP_TICKS > BIT_TICKS) ? GAP_TICKS : BIT_TICKS,
  localparam int TICK_W     = $clog2(MAX_TICK + 1),
  localparam int SCNT_W     = $clog2(SKIP_PAIRS + SUM_PAIRS + 1),
  localparam int MAX_PER    = (ACK_PERIODS > WORD_W) ? ACK_PERIODS : WORD_W,
  localparam int PER_W      = $clog2(MAX_PER + 1),
  localparam int CNT_W      = $clog2(WORD_W + 1),
  localparam int IDX_W      = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRx,
  input  logic             ackMode,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             sampleValid,
  input  logic             rawBit,
  output dp_ctrl_t         ctrl,
  output logic [IDX_W-1:0] bitIdx,
  output logic             keyStep,
  output logic             busy,
  output logic             done,
  output logic             ackSeen,
  output logic             ackTimeout
);

  demod_state_t      state;
  logic [TICK_W-1:0] tickCnt;
  logic [SCNT_W-1:0] sampleCnt;
  logic [PER_W-1:0]  periodCnt;
  logic [PER_W-1:0]  lastIdx;
  logic              ackRun;
  logic              bitEnd;
  logic              windowDone;
  logic              inWindow;
  logic              startNow;

  assign startNow   = (state == ST_IDLE) && startRx;
  assign bitEnd     = (state == ST_BITS) && (tickCnt == TICK_W'(BIT_TICKS - 1));
  assign windowDone = (sampleCnt == SCNT_W'(SKIP_PAIRS + SUM_PAIRS));
  assign inWindow   = (sampleCnt >= SCNT_W'(SKIP_PAIRS)) && !windowDone;

  always_comb begin
    ctrl.clrAcc   = bitEnd || startNow;
    ctrl.accEn    = (state == ST_BITS) && sampleValid && inWindow && !bitEnd;
    ctrl.clrWord  = startNow;
    ctrl.storeBit = bitEnd && !ackRun;
  end

  assign keyStep = bitEnd;
  assign busy    = (state != ST_IDLE);
  assign bitIdx  = periodCnt[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tickCnt    <= '0;
      sampleCnt  <= '0;
      periodCnt  <= '0;
      lastIdx    <= '0;
      ackRun     <= 1'b0;
      done       <= 1'b0;
      ackSeen    <= 1'b0;
      ackTimeout <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startRx) begin
            state      <= ST_GAP;
            tickCnt    <= '0;
            periodCnt  <= '0;
            ackRun     <= ackMode;
            ackSeen    <= 1'b0;
            ackTimeout <= 1'b0;
            if (bitCount == '0 || bitCount > CNT_W'(WORD_W))
              lastIdx <= PER_W'(WORD_W - 1);
            else
              lastIdx <= PER_W'(bitCount - 1'b1);
          end
        end
        ST_GAP: begin
          if (tickCnt == TICK_W'(GAP_TICKS - 1)) begin
            state     <= ST_BITS;
            tickCnt   <= '0;
            sampleCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (bitEnd) begin
            tickCnt   <= '0;
            sampleCnt <= '0;
            periodCnt <= periodCnt + 1'b1;
            if (!ackRun) begin
              if (periodCnt == lastIdx) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end else if (rawBit) begin
              state   <= ST_IDLE;
              done    <= 1'b1;
              ackSeen <= 1'b1;
            end else if (periodCnt == PER_W'(ACK_PERIODS - 1)) begin
              state      <= ST_IDLE;
              done       <= 1'b1;
              ackTimeout <= 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
            if (sampleValid && !windowDone)
              sampleCnt <= sampleCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iq_demod_datapath.sv
module iq_demod_datapath
  import iq_demod_pkg::*;
#(
  parameter int ACC_W     = 12,
  parameter int WORD_W    = 32,
  parameter int SUM_PAIRS = 8,
  parameter int THRESH    = 8,
  localparam int AVG_SHIFT = $clog2(SUM_PAIRS),
  localparam int IDX_W     = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctrl,
  input  logic [15:0]       sampleIq,
  input  logic              keyBit,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              rawBit,
  output logic [WORD_W-1:0] rxWord
);

  logic [ACC_W-1:0] mag [2];
  logic [ACC_W-1:0] bigMag;
  logic [ACC_W-1:0] smallMag;
  logic [ACC_W:0]   amp;

  // channel 0 = I (upper byte), channel 1 = Q (lower byte)
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [7:0]       smp;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] negAcc;

    assign smp    = sampleIq[15-8*ch -: 8];
    assign negAcc = -acc;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        acc <= '0;
      else if (ctrl.clrAcc)
        acc <= '0;
      else if (ctrl.accEn)
        acc <= acc + {{(ACC_W-8){smp[7]}}, smp};
    end

    assign mag[ch] = acc[ACC_W-1] ? $unsigned(negAcc) : $unsigned(acc);
  end

  always_comb begin
    if (mag[0] >= mag[1]) begin
      bigMag   = mag[0];
      smallMag = mag[1];
    end else begin
      bigMag   = mag[1];
      smallMag = mag[0];
    end
    amp    = {1'b0, bigMag} + {2'b00, smallMag[ACC_W-1:1]};
    rawBit = (amp >> AVG_SHIFT) > (ACC_W+1)'(THRESH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rxWord <= '0;
    else if (ctrl.clrWord)
      rxWord <= '0;
    else if (ctrl.storeBit)
      rxWord[bitIdx] <= rawBit ^ keyBit;
  end

endmodule

// File: rtl/iq_bit_demod.sv
module iq_bit_demod
  import iq_demod_pkg::*;
#(
  parameter int GAP_TICKS   = 495,
  parameter int BIT_TICKS   = 150,
  parameter int SKIP_PAIRS  = 5,
  parameter int SUM_PAIRS   = 8,
  parameter int THRESH      = 8,
  parameter int ACK_PERIODS = 60,
  parameter int WORD_W      = 32,
  parameter int ACC_W       = 12,
  localparam int CNT_W      = $clog2(WORD_W + 1),
  localparam int IDX_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRx,
  input  logic              ackMode,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic              sampleValid,
  input  logic [15:0]       sampleIq,
  input  logic              keyBit,
  output logic              keyStep,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rxWord,
  output logic              ackSeen,
  output logic              ackTimeout
);

  dp_ctrl_t         ctrl;
  logic [IDX_W-1:0] bitIdx;
  logic             rawBit;

  iq_demod_ctrl #(
    .GAP_TICKS  (GAP_TICKS),
    .BIT_TICKS  (BIT_TICKS),
    .SKIP_PAIRS (SKIP_PAIRS),
    .SUM_PAIRS  (SUM_PAIRS),
    .ACK_PERIODS(ACK_PERIODS),
    .WORD_W     (WORD_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startRx    (startRx),
    .ackMode    (ackMode),
    .bitCount   (bitCount),
    .sampleValid(sampleValid),
    .rawBit     (rawBit),
    .ctrl       (ctrl),
    .bitIdx     (bitIdx),
    .keyStep    (keyStep),
    .busy       (busy),
    .done       (done),
    .ackSeen    (ackSeen),
    .ackTimeout (ackTimeout)
  );

  iq_demod_datapath #(
    .ACC_W    (ACC_W),
    .WORD_W   (WORD_W),
    .SUM_PAIRS(SUM_PAIRS),
    .THRESH   (THRESH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .sampleIq(sampleIq),
    .keyBit  (keyBit),
    .bitIdx  (bitIdx),
    .rawBit  (rawBit),
    .rxWord  (rxWord)
  );

endmodule

// File: rtl/iq_demod_checker.sv
module iq_demod_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startRx,
  input logic              keyStep,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] rxWord,
  input logic              ackSeen,
  input logic              ackTimeout
);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startRx) |=> $stable(rxWord));

  p_step_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    keyStep |-> busy);

  p_step_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    keyStep |=> !keyStep);

  p_ack_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ackSeen && ackTimeout));

  p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackSeen || ackTimeout) |-> !busy);

endmodule

bind iq_bit_demod iq_demod_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startRx   (startRx),
  .keyStep   (keyStep),
  .busy      (busy),
  .done      (done),
  .rxWord    (rxWord),
  .ackSeen   (ackSeen),
  .ackTimeout(ackTimeout)
);

// File: tb/test_iq_bit_demod.sv
`timescale 1ns/1ps
module test_iq_bit_demod;

  localparam int GAP   = 495;
  localparam int BITT  = 150;
  localparam int SPACE = 7;
  localparam int PAIRS = 21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startRx = 1'b0;
  logic        ackMode = 1'b0;
  logic [5:0]  bitCount = '0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleIq = '0;
  logic        keyBit;
  logic        keyStep, busy, done, ackSeen, ackTimeout;
  logic [31:0] rxWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // bench keystream: 7-bit LFSR stepped by keyStep
  logic [6:0] lfsr = 7'h55;
  int stepCount = 0;
  assign keyBit = lfsr[0];
  always @(posedge clk) if (keyStep) begin
    lfsr <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    stepCount <= stepCount + 1;
  end

  iq_bit_demod i_iq_bit_demod (
    .clk(clk), .rstN(rstN), .startRx(startRx), .ackMode(ackMode),
    .bitCount(bitCount), .sampleValid(sampleValid), .sampleIq(sampleIq),
    .keyBit(keyBit), .keyStep(keyStep), .busy(busy), .done(done),
    .rxWord(rxWord), .ackSeen(ackSeen), .ackTimeout(ackTimeout)
  );

  int patI [64];
  int patQ [64];
  bit noiseOn = 0;
  bit gapNoise = 0;
  int periodsRun = 0;
  logic [6:0] keySnap;

  function automatic bit keyAt(logic [6:0] s, int k);
    for (int i = 0; i < k; i++) s = {s[5:0], s[6] ^ s[5]};
    return s[0];
  endfunction

  function automatic bit decide(int vi, int vq);
    int a = (vi * 8 < 0) ? -vi * 8 : vi * 8;
    int b = (vq * 8 < 0) ? -vq * 8 : vq * 8;
    int amp = (a >= b) ? a + b / 2 : b + a / 2;
    return (amp / 8) > 8;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // runs one operation; stops after done or maxPeriods periods
  task automatic runFrame(int nBits, bit ack, int maxPeriods);
    keySnap = lfsr;
    periodsRun = 0;
    @(negedge clk);
    startRx = 1; bitCount = 6'(nBits); ackMode = ack;
    @(negedge clk);
    startRx = 0;
    for (int g = 0; g < GAP; g++) begin
      sampleValid = gapNoise;
      sampleIq = 16'h7F7F;
      @(negedge clk);
    end
    for (int p = 0; p < maxPeriods; p++) begin
      for (int c = 0; c < BITT; c++) begin
        int j = c / SPACE;
        if (c % SPACE == 0 && j < PAIRS) begin
          sampleValid = 1;
          if (j < 5 || j >= 13)
            sampleIq = noiseOn ? 16'h7F80 : 16'h0000;
          else
            sampleIq = {8'(patI[p]), 8'(patQ[p])};
        end else begin
          sampleValid = 0;
          sampleIq = 16'hFFFF;
        end
        @(negedge clk);
      end
      periodsRun++;
      if (done) break;
    end
    sampleValid = 0;
  endtask

  task automatic checkRxWord(int nBits, string req);
    logic [31:0] exp = '0;
    for (int b = 0; b < nBits; b++) exp[b] = decide(patI[b], patQ[b]) ^ keyAt(keySnap, b);
    check(done === 1'b1, "R7", "done after last bit", done, 1);
    check(busy === 1'b0, "R7", "busy after last bit", busy, 0);
    check(rxWord === exp, req, "rxWord", rxWord, exp);
    check(stepCount == nBits, "R6", "keyStep count", stepCount, nBits);
    @(negedge clk);
    check(done === 1'b0, "R7", "done single cycle", done, 0);
  endtask

  task automatic test_reset();
    check(busy === 0 && done === 0 && keyStep === 0, "R1", "control outs",
          {busy, done, keyStep}, 0);
    check(rxWord === 0 && ackSeen === 0 && ackTimeout === 0, "R1", "data outs",
          {rxWord, ackSeen, ackTimeout}, 0);
  endtask

  task automatic test_alternate();
    for (int b = 0; b < 8; b++) begin patI[b] = (b % 2) ? 20 : 0; patQ[b] = 0; end
    noiseOn = 0; gapNoise = 0; stepCount = 0;
    runFrame(8, 0, 8);
    checkRxWord(8, "R5");
  endtask

  task automatic test_threshold();
    patI[0] = 9;   patQ[0] = 0;
    patI[1] = 8;   patQ[1] = 0;
    patI[2] = 6;   patQ[2] = 6;
    patI[3] = 6;   patQ[3] = 4;
    patI[4] = -9;  patQ[4] = 0;
    patI[5] = 0;   patQ[5] = -9;
    patI[6] = -128; patQ[6] = 127;
    patI[7] = 4;   patQ[7] = 7;
    noiseOn = 0; gapNoise = 0; stepCount = 0;
    runFrame(8, 0, 8);
    checkRxWord(8, "R4");
  endtask

  task automatic test_window();
    // strong pairs in gap, skip and tail slots must not count (R2, R3)
    for (int b = 0; b < 16; b++) begin patI[b] = (b % 3 == 0) ? -12 : 0; patQ[b] = 0; end
    noiseOn = 1; gapNoise = 1; stepCount = 0;
    runFrame(16, 0, 16);
    checkRxWord(16, "R3");
    noiseOn = 0; gapNoise = 0;
  endtask

  task automatic test_full_word();
    for (int b = 0; b < 32; b++) begin
      patI[b] = ((b * 37) % 11) - 5 + ((b % 4 == 1) ? 30 : 0);
      patQ[b] = ((b * 13) % 7) - 3 - ((b % 5 == 2) ? 40 : 0);
    end
    stepCount = 0;
    runFrame(32, 0, 32);
    checkRxWord(32, "R5");
  endtask

  task automatic test_short_word();
    patI[0] = 50; patQ[0] = 50;
    stepCount = 0;
    runFrame(1, 0, 1);
    checkRxWord(1, "R5");
    // idle samples do not disturb held word (R7)
    begin
      logic [31:0] held = rxWord;
      sampleValid = 1; sampleIq = 16'h7F7F;
      repeat (300) @(negedge clk);
      sampleValid = 0;
      check(rxWord === held && busy === 0, "R7", "word held while idle", rxWord, held);
    end
  endtask

  task automatic test_ack_found();
    for (int b = 0; b < 64; b++) begin patI[b] = 0; patQ[b] = 0; end
    patI[4] = 20;
    stepCount = 0;
    runFrame(0, 1, 60);
    check(periodsRun == 5, "R8", "ack period count", periodsRun, 5);
    check(done === 1 && ackSeen === 1 && ackTimeout === 0, "R8", "ack flags",
          {done, ackSeen, ackTimeout}, 3'b110);
    check(stepCount == 5, "R6", "ack keyStep count", stepCount, 5);
    @(negedge clk);
  endtask

  task automatic test_ack_timeout();
    for (int b = 0; b < 64; b++) begin patI[b] = 0; patQ[b] = 0; end
    stepCount = 0;
    runFrame(0, 1, 61);
    check(periodsRun == 60, "R9", "timeout period count", periodsRun, 60);
    check(done === 1 && ackSeen === 0 && ackTimeout === 1, "R9", "timeout flags",
          {done, ackSeen, ackTimeout}, 3'b101);
    @(negedge clk);
    check(ackTimeout === 1 && busy === 0, "R9", "timeout held", ackTimeout, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1;
    @(negedge clk);
    test_alternate();
    test_threshold();
    test_window();
    test_full_word();
    test_short_word();
    test_ack_found();
    test_ack_timeout();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule